// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits beside the write path of a byte-wide parallel flash and watches every host write (address and data). It recognises the keyed command sequences that unlock privileged operations. All of them open with the same two key writes. A three-write form either arms software write protection or leaves product-identification mode. A six-write form, whose final byte picks the action, lifts protection, starts a whole-array erase, or enters product-identification mode. The array, its programming timer and its erase engine are outside this block. The block hands them a byte-load strobe with address and data, a programming-start pulse and an erase-start pulse.

Ordinary data writes pass through a gate. When protection is lifted, any plain write loads a byte and opens a page-load window. When protection is armed, a byte is loaded only inside a window that the arming sequence opened. The window closes after a parameterised number of idle cycles. If at least one byte was loaded, internal programming is then requested. An erase holds the block busy for a parameterised count, which stands in for the nominal erase time. While in identification mode, a read port returns the maker and device codes.

Top module: `flash_unlock_decoder`

## Requirements
- R1: After reset, protection is armed (`prot_on`=1), and `id_mode`, `erase_busy`, `page_open`, `load_stb`, `prog_start` and `erase_start` are all 0.
- R2: Writes of AAh to 5555h, 55h to 2AAAh and then A0h to 5555h set `prot_on` and raise `page_open` in the cycle after the third write, without a byte load.
- R3: With `prot_on`=1 and no window open, a plain data write produces no `load_stb` and opens no window.
- R4: With `prot_on`=0, a plain data write pulses `load_stb` for one cycle in the cycle after the write, with `load_addr`/`load_data` equal to the written values, and raises `page_open`.
- R5: While `page_open`=1, every write is a data byte (it is loaded even if it matches a key). Each load restarts the window. The window stays open for exactly `LOAD_TIMEOUT` cycles after the last load or arming write. On closing, it pulses `prog_start` for one cycle if at least one byte was loaded, and otherwise stays quiet.
- R6: The six-write sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clears `prot_on`. No other write clears it.
- R7: The same six-write sequence ending in 10h pulses `erase_start` for one cycle and holds `erase_busy` high for exactly `ERASE_CYCLES` cycles. Writes made while busy are ignored: they advance no sequence and load no byte.
- R8: The six-write sequence ending in 60h sets `id_mode`. The three-write sequence AAh@5555h, 55h@2AAAh, F0h@5555h clears it.
- R9: With `id_mode`=1, `rd_addr`=0 gives `id_data`=DAh and `rd_addr`=1 gives C1h, both with `id_hit`=1. Any other address, or `id_mode`=0, gives `id_hit`=0 and `id_data`=00h.
- R10: Command addresses are compared on `wr_addr[14:0]` only, so higher address bits do not affect sequence matching.
- R11: A write that is not the expected next step returns the decoder to idle. That write is then handled as a plain data write under the R3/R4 gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle it is high |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | ADDR_W | Read address for the identification codes |
| prot_on | output | 1 | Software write protection armed |
| id_mode | output | 1 | Product-identification mode active |
| id_data | output | 8 | Identification code for `rd_addr` |
| id_hit | output | 1 | `id_data` holds a valid code |
| page_open | output | 1 | Page-load window open |
| load_stb | output | 1 | One-cycle byte-load strobe to the page buffer |
| load_addr | output | ADDR_W | Address of the loaded byte |
| load_data | output | 8 | Value of the loaded byte |
| prog_start | output | 1 | One-cycle internal programming request |
| erase_start | output | 1 | One-cycle chip-erase request |
| erase_busy | output | 1 | Erase in progress |

## Verification
The final byte of the six-write sequence is swept over all 256 values with protection armed. This separates the three recognised selectors from every other value, each of which must fall back to a blocked data write. The third byte of the short sequence is swept over all 256 values with protection lifted. This separates arming, the six-write continuation and identification exit from plain loads. Directed runs vary the key addresses in the ignored upper bits, break a sequence partway, fill and let the window expire, and issue command writes during an erase. Each such run tells gating, window timing and busy blocking apart from sequence matching.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;

  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] KEY_ADDR_HI = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_LO = 15'h2AAA;

  localparam logic [7:0] KEY_BYTE_1  = 8'hAA;
  localparam logic [7:0] KEY_BYTE_2  = 8'h55;
  localparam logic [7:0] OP_ARM      = 8'hA0;
  localparam logic [7:0] OP_EXTEND   = 8'h80;
  localparam logic [7:0] OP_ID_LEAVE = 8'hF0;
  localparam logic [7:0] OP_UNARM    = 8'h20;
  localparam logic [7:0] OP_WIPE     = 8'h10;
  localparam logic [7:0] OP_ID_ENTER = 8'h60;

  // Position inside a keyed sequence: how many steps have matched so far.
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_EXT,
    SQ_EXT_KEY1,
    SQ_EXT_KEY2
  } seq_state_t;

  typedef enum logic [2:0] {
    DO_MISS,
    DO_STEP,
    DO_ARM,
    DO_UNARM,
    DO_WIPE,
    DO_ID_ON,
    DO_ID_OFF
  } seq_action_t;

  function automatic logic key_hit(input logic [CMD_AW-1:0] a,
                                   input logic [7:0]        d,
                                   input logic [CMD_AW-1:0] ka,
                                   input logic [7:0]        kd);
    return (a == ka) && (d == kd);
  endfunction

  // Action that a write (a, d) triggers in sequence position st.
  function automatic seq_action_t decode_step(input seq_state_t       st,
                                              input logic [CMD_AW-1:0] a,
                                              input logic [7:0]        d);
    seq_action_t act;
    act = DO_MISS;
    case (st)
      SQ_IDLE: if (key_hit(a, d, KEY_ADDR_HI, KEY_BYTE_1)) act = DO_STEP;
      SQ_KEY1: if (key_hit(a, d, KEY_ADDR_LO, KEY_BYTE_2)) act = DO_STEP;
      SQ_KEY2: begin
        if      (key_hit(a, d, KEY_ADDR_HI, OP_ARM))      act = DO_ARM;
        else if (key_hit(a, d, KEY_ADDR_HI, OP_EXTEND))   act = DO_STEP;
        else if (key_hit(a, d, KEY_ADDR_HI, OP_ID_LEAVE)) act = DO_ID_OFF;
      end
      SQ_EXT:      if (key_hit(a, d, KEY_ADDR_HI, KEY_BYTE_1)) act = DO_STEP;
      SQ_EXT_KEY1: if (key_hit(a, d, KEY_ADDR_LO, KEY_BYTE_2)) act = DO_STEP;
      SQ_EXT_KEY2: begin
        if      (key_hit(a, d, KEY_ADDR_HI, OP_UNARM))    act = DO_UNARM;
        else if (key_hit(a, d, KEY_ADDR_HI, OP_WIPE))     act = DO_WIPE;
        else if (key_hit(a, d, KEY_ADDR_HI, OP_ID_ENTER)) act = DO_ID_ON;
      end
      default: act = DO_MISS;
    endcase
    return act;
  endfunction

  function automatic seq_state_t advance(input seq_state_t st);
    case (st)
      SQ_IDLE:     return SQ_KEY1;
      SQ_KEY1:     return SQ_KEY2;
      SQ_KEY2:     return SQ_EXT;
      SQ_EXT:      return SQ_EXT_KEY1;
      SQ_EXT_KEY1: return SQ_EXT_KEY2;
      default:     return SQ_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/unlock_step_match.sv
module unlock_step_match
  import flash_unlock_pkg::*;
(
  input  seq_state_t        seq_st,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output seq_action_t       seq_act,
  output seq_state_t        seq_nxt
);

  always_comb begin
    seq_act = decode_step(seq_st, cmd_addr, cmd_data);
    seq_nxt = (seq_act == DO_STEP) ? advance(seq_st) : SQ_IDLE;
  end

endmodule

// File: rtl/load_window_timer.sv
module load_window_timer #(
  parameter int LOAD_TIMEOUT = 37500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic load_req,
  output logic page_open,
  output logic prog_start
);

  localparam int LW = $clog2(LOAD_TIMEOUT + 1);

  logic [LW-1:0] left_q;
  logic          loaded_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_open  <= 1'b0;
      prog_start <= 1'b0;
      left_q     <= '0;
      loaded_q   <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      if (load_req) begin
        page_open <= 1'b1;
        left_q    <= LW'(LOAD_TIMEOUT);
        loaded_q  <= 1'b1;
      end else if (arm_req) begin
        page_open <= 1'b1;
        left_q    <= LW'(LOAD_TIMEOUT);
        loaded_q  <= 1'b0;
      end else if (page_open) begin
        if (left_q == LW'(1)) begin
          page_open  <= 1'b0;
          prog_start <= loaded_q;
          loaded_q   <= 1'b0;
        end else begin
          left_q <= left_q - LW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/erase_busy_timer.sv
module erase_busy_timer #(
  parameter int ERASE_CYCLES = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int EW = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;

  logic [EW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      left_q <= EW'(ERASE_CYCLES - 1);
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - EW'(1);
    end
  end

endmodule

// File: rtl/id_code_rom.sv
module id_code_rom #(
  parameter int         ADDR_W   = 17,
  parameter logic [7:0] MFR_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'hC1
) (
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        id_data,
  output logic              id_hit
);

  always_comb begin
    id_hit  = 1'b0;
    id_data = 8'h00;
    if (id_mode) begin
      if (rd_addr == ADDR_W'(0)) begin
        id_hit  = 1'b1;
        id_data = MFR_CODE;
      end else if (rd_addr == ADDR_W'(1)) begin
        id_hit  = 1'b1;
        id_data = DEV_CODE;
      end
    end
  end

endmodule

// File: rtl/flash_unlock_decoder.sv
module flash_unlock_decoder
  import flash_unlock_pkg::*;
#(
  parameter int         ADDR_W       = 17,
  parameter int         LOAD_TIMEOUT = 37500,
  parameter int         ERASE_CYCLES = 400000,
  parameter logic [7:0] MFR_CODE     = 8'hDA,
  parameter logic [7:0] DEV_CODE     = 8'hC1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prot_on,
  output logic              id_mode,
  output logic [7:0]        id_data,
  output logic              id_hit,
  output logic              page_open,
  output logic              load_stb,
  output logic [ADDR_W-1:0] load_addr,
  output logic [7:0]        load_data,
  output logic              prog_start,
  output logic              erase_start,
  output logic              erase_busy
);

  logic [CMD_AW-1:0] cmd_addr;
  seq_state_t        seq_q;
  seq_state_t        seq_nxt;
  seq_action_t       seq_act;

  // Named events for the checker.
  logic wr_live;
  logic cmd_live;
  logic data_wr;
  logic accept_wr;
  logic arm_window;
  logic erase_go;

  assign cmd_addr   = wr_addr[CMD_AW-1:0];
  assign wr_live    = wr_en && !erase_busy;
  assign cmd_live   = wr_live && !page_open;
  assign data_wr    = wr_live && (page_open || (seq_act == DO_MISS));
  assign accept_wr  = data_wr && (page_open || !prot_on);
  assign arm_window = cmd_live && (seq_act == DO_ARM);
  assign erase_go   = cmd_live && (seq_act == DO_WIPE);

  unlock_step_match u_match (
    .seq_st   (seq_q),
    .cmd_addr (cmd_addr),
    .cmd_data (wr_data),
    .seq_act  (seq_act),
    .seq_nxt  (seq_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q       <= SQ_IDLE;
      prot_on     <= 1'b1;
      id_mode     <= 1'b0;
      erase_start <= 1'b0;
      load_stb    <= 1'b0;
      load_addr   <= '0;
      load_data   <= '0;
    end else begin
      erase_start <= erase_go;
      load_stb    <= accept_wr;
      if (accept_wr) begin
        load_addr <= wr_addr;
        load_data <= wr_data;
      end
      if (cmd_live) begin
        seq_q <= seq_nxt;
        case (seq_act)
          DO_ARM:    prot_on <= 1'b1;
          DO_UNARM:  prot_on <= 1'b0;
          DO_ID_ON:  id_mode <= 1'b1;
          DO_ID_OFF: id_mode <= 1'b0;
          default:   ;
        endcase
      end
    end
  end

  load_window_timer #(
    .LOAD_TIMEOUT (LOAD_TIMEOUT)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_req    (arm_window),
    .load_req   (accept_wr),
    .page_open  (page_open),
    .prog_start (prog_start)
  );

  erase_busy_timer #(
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_erase (
    .clk   (clk),
    .rst_n (rst_n),
    .start (erase_go),
    .busy  (erase_busy)
  );

  id_code_rom #(
    .ADDR_W   (ADDR_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_rom (
    .id_mode (id_mode),
    .rd_addr (rd_addr),
    .id_data (id_data),
    .id_hit  (id_hit)
  );

endmodule

// File: rtl/flash_unlock_checker.sv
module flash_unlock_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       prot_on,
  input logic       id_mode,
  input logic       id_hit,
  input logic       page_open,
  input logic       load_stb,
  input logic       prog_start,
  input logic       erase_start,
  input logic       erase_busy,
  input logic       accept_wr
);

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> erase_busy);

  p_busy_noload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> !load_stb);

  p_load_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_wr |=> (load_stb && page_open));

  p_load_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> ($past(page_open) || !$past(prot_on)));

  p_unarm_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> ($past(wr_en) && ($past(wr_data) == 8'h20)));

  p_prog_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (!page_open && $past(page_open)));

  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_start, load_stb, prog_start}));

  p_id_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> id_mode);

endmodule

bind flash_unlock_decoder flash_unlock_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .prot_on     (prot_on),
  .id_mode     (id_mode),
  .id_hit      (id_hit),
  .page_open   (page_open),
  .load_stb    (load_stb),
  .prog_start  (prog_start),
  .erase_start (erase_start),
  .erase_busy  (erase_busy),
  .accept_wr   (accept_wr)
);

// File: tb/sim_flash_unlock_decoder.sv
`timescale 1ns/1ps
module sim_flash_unlock_decoder;

  localparam int AW = 17;
  localparam int TO = 6;
  localparam int EC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          prot_on, id_mode, id_hit, page_open, load_stb;
  logic          prog_start, erase_start, erase_busy;
  logic [7:0]    id_data, load_data;
  logic [AW-1:0] load_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  flash_unlock_decoder #(
    .ADDR_W (AW), .LOAD_TIMEOUT (TO), .ERASE_CYCLES (EC)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .prot_on (prot_on),
    .id_mode (id_mode), .id_data (id_data), .id_hit (id_hit),
    .page_open (page_open), .load_stb (load_stb), .load_addr (load_addr),
    .load_data (load_data), .prog_start (prog_start),
    .erase_start (erase_start), .erase_busy (erase_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic keys();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  task automatic six(input logic [7:0] last);
    keys();
    wr(17'h05555, 8'h80);
    keys();
    wr(17'h05555, last);
  endtask

  // Called in cycle 1 of a window; walks it to expiry.
  task automatic wait_close(input string req, input logic exp_prog);
    idle(TO - 1);
    chk(req, page_open, 1);
    idle(1);
    chk(req, page_open, 0);
    chk(req, prog_start, exp_prog);
    idle(1);
    chk(req, prog_start, 0);
  endtask

  task automatic erase_wait(input string req, input bit check_len);
    int n = 0;
    while (erase_busy && n < 1000) begin
      idle(1);
      n++;
    end
    if (check_len) chk(req, n, EC);
  endtask

  task automatic arm();
    keys();
    wr(17'h05555, 8'hA0);
    wait_close("R2 rearm", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 prot", prot_on, 1);
    chk("R1 id", id_mode, 0);
    chk("R1 busy", erase_busy, 0);
    chk("R1 open", page_open, 0);
    chk("R1 pulses", {load_stb, prog_start, erase_start}, 0);

    // R3 protected plain write blocked
    wr(17'h00100, 8'h12);
    chk("R3 load", load_stb, 0);
    chk("R3 open", page_open, 0);

    // R2 arming opens a window; R5 loads inside it
    keys();
    wr(17'h05555, 8'hA0);
    chk("R2 prot", prot_on, 1);
    chk("R2 open", page_open, 1);
    chk("R2 noload", load_stb, 0);
    wr(17'h00080, 8'h11);
    chk("R5 load", load_stb, 1);
    chk("R5 data", load_data, 8'h11);
    wr(17'h05555, 8'hAA);
    chk("R5 key as data", load_stb, 1);
    chk("R5 key addr", load_addr, 17'h05555);
    wait_close("R5 close", 1);
    chk("R5 still protected", prot_on, 1);

    // R5 arming alone: window expires without programming
    keys();
    wr(17'h05555, 8'hA0);
    wait_close("R5 empty", 0);

    // R6 unarm, R4 plain load
    six(8'h20);
    chk("R6 prot", prot_on, 0);
    chk("R6 open", page_open, 0);
    wr(17'h1ABCD, 8'h5A);
    chk("R4 load", load_stb, 1);
    chk("R4 addr", load_addr, 17'h1ABCD);
    chk("R4 data", load_data, 8'h5A);
    chk("R4 open", page_open, 1);
    idle(TO - 3);
    wr(17'h00001, 8'h66);
    chk("R5 restart", load_stb, 1);
    wait_close("R5 restart close", 1);

    // R11 broken sequence, write becomes a plain load
    wr(17'h05555, 8'hAA);
    chk("R11 consumed", load_stb, 0);
    wr(17'h00010, 8'h77);
    chk("R11 load", load_stb, 1);
    chk("R11 data", load_data, 8'h77);
    wait_close("R11 close", 1);

    // R10 upper address bits ignored while matching
    wr(17'h15555, 8'hAA);
    wr(17'h12AAA, 8'h55);
    wr(17'h1D555, 8'hA0);
    chk("R10 prot", prot_on, 1);
    chk("R10 open", page_open, 1);
    chk("R10 noload", load_stb, 0);
    wait_close("R10 close", 0);

    // R11 under protection: a break leaves decoder idle, later A0 is data
    wr(17'h05555, 8'hAA);
    wr(17'h01234, 8'h55);
    wr(17'h05555, 8'hA0);
    chk("R11 no window", page_open, 0);
    chk("R11 blocked", load_stb, 0);

    // R8 / R9 identification mode
    six(8'h60);
    chk("R8 enter", id_mode, 1);
    rd_addr = 17'h00000; #1 chk("R9 mfr", {id_hit, id_data}, {1'b1, 8'hDA});
    rd_addr = 17'h00001; #1 chk("R9 dev", {id_hit, id_data}, {1'b1, 8'hC1});
    rd_addr = 17'h00002; #1 chk("R9 other", {id_hit, id_data}, 9'h000);
    rd_addr = 17'h10000; #1 chk("R9 high", {id_hit, id_data}, 9'h000);
    keys();
    wr(17'h05555, 8'hF0);
    chk("R8 leave", id_mode, 0);
    rd_addr = 17'h00000; #1 chk("R9 off", {id_hit, id_data}, 9'h000);

    // R7 erase length
    six(8'h10);
    chk("R7 start", erase_start, 1);
    chk("R7 busy", erase_busy, 1);
    idle(1);
    chk("R7 pulse", erase_start, 0);
    erase_wait("R7 length", 1'b0);
    six(8'h10);
    erase_wait("R7 length", 1'b1);

    // R7 writes ignored while busy
    six(8'h10);
    six(8'h20);
    wr(17'h00044, 8'h44);
    chk("R7 ignored load", load_stb, 0);
    erase_wait("R7 tail", 1'b0);
    chk("R7 ignored unarm", prot_on, 1);
    wr(17'h00044, 8'h44);
    chk("R7 after busy", load_stb, 0);

    // Sweep final selector byte, protection armed
    for (int v = 0; v < 256; v++) begin
      six(8'(v));
      if (v == 8'h20) begin
        chk("R6 sweep", prot_on, 0);
        arm();
      end else if (v == 8'h10) begin
        chk("R7 sweep", erase_start, 1);
        erase_wait("R7 sweep", 1'b1);
      end else if (v == 8'h60) begin
        chk("R8 sweep", id_mode, 1);
        keys();
        wr(17'h05555, 8'hF0);
        chk("R8 sweep exit", id_mode, 0);
      end else begin
        chk("R11 sweep prot", prot_on, 1);
        chk("R11 sweep id", id_mode, 0);
        chk("R11 sweep busy", erase_busy, 0);
        chk("R3 sweep load", load_stb, 0);
      end
    end

    // Sweep third byte, protection lifted
    six(8'h20);
    for (int v = 0; v < 256; v++) begin
      keys();
      wr(17'h05555, 8'(v));
      if (v == 8'hA0) begin
        chk("R2 sweep", {prot_on, page_open, load_stb}, 3'b110);
        wait_close("R2 sweep", 0);
        six(8'h20);
      end else if (v == 8'h80) begin
        chk("R11 sweep ext", {prot_on, page_open, load_stb}, 3'b000);
        wr(17'h00000, 8'h00);
        chk("R11 sweep abort", load_stb, 1);
        wait_close("R11 sweep abort", 1);
      end else if (v == 8'hF0) begin
        chk("R8 sweep f0", {id_mode, page_open, load_stb}, 3'b000);
      end else begin
        chk("R4 sweep load", {load_stb, page_open}, 2'b11);
        chk("R4 sweep data", load_data, 32'(v));
        wait_close("R4 sweep", 1);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule